// File: doc/BRIEF.md
# Reset Cause Sequencer

This block owns the chip's bidirectional reset pin and decides, after every reset, which reset vector the processor should fetch. It has four inputs that can start a reset: power-on, the external pin pulled low, a watchdog timeout and a clock-monitor failure. After power-on it holds the system in reset for a fixed number of cycles of a running oscillator. After every other reset cause it pulls the pin low itself for a few cycles, releases it, and then reads it back a fixed delay later.

If the pin is still low when it is read back, something outside the chip is holding it, so the reset is classed as external. If the pin reads high, the reset came from inside the chip. The latched clock-monitor fault then wins over a latched watchdog fault. If neither fault is latched, the normal vector is used. On leaving reset the block opens a three-cycle vector-fetch window and strobes a request to set the stop-disable and both interrupt-mask bits of the condition register.

All timing is counted in bus-clock cycles by one synchronous state machine. The pin is modelled as an open-drain line: the block drives a pull-down enable and reads the resolved pin level.

Top module: `reset_cause_seq`

## Requirements
- R1: While rst_ni is low, sys_rst_o is 1 and pin_drive_o, fetch_o and mask_set_o are 0, with vec_sel_o = 2'b00. After rst_ni rises, sys_rst_o stays 1 while osc_ok_i is low. It falls at the POR_CYCLES-th consecutive rising edge with osc_ok_i high (default 4064), and the vector code is 2'b00.
- R2: In normal operation, a low pin_i, a high clkmon_fail_i, a high wdog_fail_i or a latched fault starts a reset at the next rising edge. sys_rst_o rises at that edge, and pin_drive_o is 1 for exactly DRIVE_CYCLES (4) cycles from that edge. With none of these present, no reset starts.
- R3: pin_i is sampled at the SAMPLE_DELAY-th (2nd) rising edge after pin_drive_o falls. If it is low, vec_sel_o becomes 2'b00 (external) regardless of any latched fault.
- R4: If the pin reads high at the sample and a clock-monitor fault is latched, vec_sel_o becomes 2'b01, even when a watchdog fault is also latched.
- R5: If the pin reads high at the sample and only a watchdog fault is latched, vec_sel_o becomes 2'b10.
- R6: If the pin reads high at the sample and no fault is latched, vec_sel_o becomes 2'b00 (normal).
- R7: At the sampling edge sys_rst_o falls and fetch_o is 1 for exactly FETCH_CYCLES (3) cycles. mask_set_o pulses in the first of those cycles only. sys_rst_o stays 0 during the fetch window.
- R8: A single-cycle fault pulse is latched outside power-on. This holds even during the fetch window, and such a fault starts a new reset once the fetch window ends. The latches are cleared at the sampling edge.
- R9: vec_sel_o changes only at the edge that opens a fetch window and otherwise holds its value. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| osc_ok_i | input | 1 | Oscillator running indication |
| pin_i | input | 1 | Resolved level of the reset pin |
| clkmon_fail_i | input | 1 | Clock-monitor failure request |
| wdog_fail_i | input | 1 | Watchdog timeout request |
| sys_rst_o | output | 1 | Held system reset |
| pin_drive_o | output | 1 | Pull-down enable for the reset pin |
| fetch_o | output | 1 | Vector-fetch window |
| mask_set_o | output | 1 | Request to set the S, X and I condition bits |
| vec_sel_o | output | 2 | Vector select: 00 normal/external, 01 clock monitor, 10 watchdog |

## Verification
Counting from the edge that starts a reset, the bench expects the following. pin_drive_o is high after edges 0 to 3, and sys_rst_o stays high through edge 5. At edge 6 the vector code appears with fetch_o and mask_set_o. The block returns to normal operation at edge 9. After power-on, release is due at the POR_CYCLES-th edge with the oscillator up. Stimulus changes on falling edges, and every output is compared on the falling edge after the counted rising edge. The bench models the open-drain pin arithmetically from the drive enable and an external hold of 1 or 7 cycles, so it can produce both a pin still low at the sample and a pin already released by then. It sweeps all fault combinations against both cases.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;
  typedef enum logic [1:0] {
    VEC_NORMAL = 2'b00,
    VEC_CLKMON = 2'b01,
    VEC_WDOG   = 2'b10
  } vec_e;

  typedef enum logic [2:0] {
    ST_POR,
    ST_RUN,
    ST_DRIVE,
    ST_SETTLE,
    ST_FETCH
  } seq_state_e;
endpackage

// File: rtl/rcs_cycle_cnt.sv
module rcs_cycle_cnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rcs_fault_latch.sv
module rcs_fault_latch #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 flag_o[g] <= 1'b0;
      else if (clr_i)              flag_o[g] <= 1'b0;
      else if (en_i && req_i[g])   flag_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/rcs_cause_sel.sv
module rcs_cause_sel
  import reset_cause_pkg::*;
(
  input  logic pin_low_i,
  input  logic clkmon_i,
  input  logic wdog_i,
  output vec_e vec_o
);
  always_comb begin
    if (pin_low_i)     vec_o = VEC_NORMAL;
    else if (clkmon_i) vec_o = VEC_CLKMON;
    else if (wdog_i)   vec_o = VEC_WDOG;
    else               vec_o = VEC_NORMAL;
  end
endmodule

// File: rtl/reset_cause_seq.sv
module reset_cause_seq
  import reset_cause_pkg::*;
#(
  parameter int POR_CYCLES   = 4064,
  parameter int DRIVE_CYCLES = 4,
  parameter int SAMPLE_DELAY = 2,
  parameter int FETCH_CYCLES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_ok_i,
  input  logic       pin_i,
  input  logic       clkmon_fail_i,
  input  logic       wdog_fail_i,
  output logic       sys_rst_o,
  output logic       pin_drive_o,
  output logic       fetch_o,
  output logic       mask_set_o,
  output logic [1:0] vec_sel_o
);
  localparam int MAX_A = (POR_CYCLES > DRIVE_CYCLES) ? POR_CYCLES : DRIVE_CYCLES;
  localparam int MAX_B = (SAMPLE_DELAY > FETCH_CYCLES) ? SAMPLE_DELAY : FETCH_CYCLES;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SAMPLE_DELAY - 1);
  localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(FETCH_CYCLES - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_clr, cnt_inc;
  logic [1:0]        flags;
  logic              sample_now;
  logic              first_fetch_q;
  vec_e              cause;
  vec_e              vec_q;
  logic              trigger;

  assign trigger = !pin_i || clkmon_fail_i || wdog_fail_i || (|flags);

  always_comb begin
    state_d    = state_q;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    sample_now = 1'b0;
    unique case (state_q)
      ST_POR: begin
        if (!osc_ok_i) cnt_clr = 1'b1;
        else if (cnt == POR_LAST) begin
          state_d = ST_FETCH;
          cnt_clr = 1'b1;
        end else cnt_inc = 1'b1;
      end
      ST_RUN: begin
        cnt_clr = 1'b1;
        if (trigger) state_d = ST_DRIVE;
      end
      ST_DRIVE: begin
        if (cnt == DRIVE_LAST) begin
          state_d = ST_SETTLE;
          cnt_clr = 1'b1;
        end else cnt_inc = 1'b1;
      end
      ST_SETTLE: begin
        if (cnt == SETTLE_LAST) begin
          state_d    = ST_FETCH;
          cnt_clr    = 1'b1;
          sample_now = 1'b1;
        end else cnt_inc = 1'b1;
      end
      ST_FETCH: begin
        if (cnt == FETCH_LAST) begin
          state_d = ST_RUN;
          cnt_clr = 1'b1;
        end else cnt_inc = 1'b1;
      end
      default: begin
        state_d = ST_POR;
        cnt_clr = 1'b1;
      end
    endcase
  end

  rcs_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  // bit 1 clock monitor, bit 0 watchdog
  rcs_fault_latch #(.N(2)) u_faults (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q != ST_POR),
    .clr_i  (sample_now),
    .req_i  ({clkmon_fail_i, wdog_fail_i}),
    .flag_o (flags)
  );

  rcs_cause_sel u_sel (
    .pin_low_i (!pin_i),
    .clkmon_i  (flags[1]),
    .wdog_i    (flags[0]),
    .vec_o     (cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_POR;
      vec_q         <= VEC_NORMAL;
      first_fetch_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      first_fetch_q <= (state_d == ST_FETCH) && (state_q != ST_FETCH);
      if (sample_now)                            vec_q <= cause;
      else if (state_q == ST_POR && state_d == ST_FETCH) vec_q <= VEC_NORMAL;
    end
  end

  assign sys_rst_o   = (state_q == ST_POR) || (state_q == ST_DRIVE) || (state_q == ST_SETTLE);
  assign pin_drive_o = (state_q == ST_DRIVE);
  assign fetch_o     = (state_q == ST_FETCH);
  assign mask_set_o  = first_fetch_q;
  assign vec_sel_o   = vec_q;
endmodule

// File: rtl/reset_cause_seq_chk.sv
module reset_cause_seq_chk #(
  parameter int DRIVE_CYCLES = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sys_rst_o,
  input logic       pin_drive_o,
  input logic       fetch_o,
  input logic       mask_set_o,
  input logic [1:0] vec_sel_o
);
  logic [7:0] drv_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          drv_run <= '0;
    else if (!pin_drive_o) drv_run <= '0;
    else if (drv_run != 8'hff) drv_run <= drv_run + 1'b1;
  end

  AST_DRIVE_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> sys_rst_o); // R2
  AST_DRIVE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_run <= 8'(DRIVE_CYCLES)); // R2
  AST_HOLD_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_drive_o) |-> sys_rst_o && !fetch_o); // R3
  AST_FETCH_OUT_OF_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> !sys_rst_o && !pin_drive_o); // R7
  AST_FETCH_FOLLOWS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_o) |-> $past(sys_rst_o)); // R7
  AST_MASK_IN_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_o |-> $rose(fetch_o)); // R7
  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_sel_o != 2'b11); // R9
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(fetch_o) |-> $stable(vec_sel_o)); // R9
endmodule

bind reset_cause_seq reset_cause_seq_chk #(.DRIVE_CYCLES(DRIVE_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sys_rst_o   (sys_rst_o),
  .pin_drive_o (pin_drive_o),
  .fetch_o     (fetch_o),
  .mask_set_o  (mask_set_o),
  .vec_sel_o   (vec_sel_o)
);

// File: tb/reset_cause_seq_tb.sv
module reset_cause_seq_tb;
  localparam int POR_CYCLES = 4064;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_ok = 1'b0;
  logic ext_hold = 1'b0;
  logic cm = 1'b0;
  logic wd = 1'b0;
  logic pin;
  logic sys_rst, pin_drive, fetch, mask_set;
  logic [1:0] vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int prev_vec = 0;

  always #4 clk = ~clk;

  assign pin = ~(pin_drive | ext_hold);

  reset_cause_seq #(.POR_CYCLES(POR_CYCLES)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .osc_ok_i      (osc_ok),
    .pin_i         (pin),
    .clkmon_fail_i (cm),
    .wdog_fail_i   (wd),
    .sys_rst_o     (sys_rst),
    .pin_drive_o   (pin_drive),
    .fetch_o       (fetch),
    .mask_set_o    (mask_set),
    .vec_sel_o     (vec)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // enters just after a falling edge with the block in normal operation
  task automatic run_seq(input int ext_len, input bit c, input bit w, input bit inj);
    int exp_vec;
    string vreq;
    if (ext_len >= 7)  begin exp_vec = 0; vreq = "R3"; end
    else if (c)        begin exp_vec = 1; vreq = "R4"; end
    else if (w)        begin exp_vec = 2; vreq = "R5"; end
    else               begin exp_vec = 0; vreq = "R6"; end
    ext_hold = (ext_len > 0);
    cm = c;
    wd = w;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j == 0) begin cm = 1'b0; wd = 1'b0; end
      if (j + 1 >= ext_len) ext_hold = 1'b0;
      check("R2", int'(pin_drive), (j <= 3) ? 1 : 0);
      check("R2", int'(sys_rst), (j <= 5) ? 1 : 0);
      check("R7", int'(fetch), (j >= 6 && j <= 8) ? 1 : 0);
      check("R7", int'(mask_set), (j == 6) ? 1 : 0);
      if (j >= 6) check(vreq, int'(vec), exp_vec);
      else        check("R9", int'(vec), prev_vec);
      if (inj && j == 6) wd = 1'b1;
      if (inj && j == 7) wd = 1'b0;
    end
    prev_vec = exp_vec;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(sys_rst), 1);
    check("R1", int'(pin_drive), 0);
    check("R1", int'(fetch), 0);
    check("R1", int'(vec), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1", int'(sys_rst), 1);
    osc_ok = 1'b1;
    for (int j = 0; j < POR_CYCLES; j++) begin
      @(negedge clk);
      if (j == POR_CYCLES - 2) check("R1", int'(sys_rst), 1);
      if (j == POR_CYCLES - 1) begin
        check("R1", int'(sys_rst), 0);
        check("R7", int'(fetch), 1);
        check("R7", int'(mask_set), 1);
        check("R1", int'(vec), 0);
      end
    end
    repeat (3) @(negedge clk);
    check("R7", int'(fetch), 0);

    // sweep pin hold length and fault combinations
    for (int e = 0; e < 3; e++) begin
      for (int f = 0; f < 4; f++) begin
        int len;
        len = (e == 0) ? 0 : (e == 1) ? 1 : 7;
        if (len == 0 && f == 0) begin
          for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R2", int'(sys_rst), 0);
            check("R2", int'(pin_drive), 0);
          end
        end else begin
          run_seq(len, f[1], f[0], 1'b0);
          @(negedge clk);
          check("R8", int'(sys_rst), 0);
        end
      end
    end

    // fault arriving in the fetch window starts a second reset
    run_seq(1, 1'b0, 1'b0, 1'b1);
    run_seq(0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    // latches were cleared: a clean pin pulse selects normal
    run_seq(1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R9", int'(vec), prev_vec);
      check("R8", int'(sys_rst), 0);
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule